// File: doc/BRIEF.md
# Nonvolatile Data Register Write Sequencer

This block owns a bank of small data registers that model nonvolatile storage for a set of digitally controlled potentiometers: four pots, each with four 6-bit registers. Commands arrive already decoded from the serial front end, one strobe per complete command. Three commands change storage. A load writes a host-supplied word into one register. A copy stores the present wiper setting of one pot into one of that pot's registers. A broadcast copy stores every pot's wiper setting into the same register index of each pot, all in one operation.

A storing command is not applied when it arrives. It waits as a pending request. It is committed only on the edge where chip select goes back high. The commit then starts a store interval of `BUSY_CYCLES` system clocks, and the busy flag is high for that interval. No new store is accepted while the flag is high. A low level on the write-protect input at the moment of commit cancels the store. The storage can be read at any time through a separate read port with one cycle of latency.

Top module: `nvw_store_seq`

## Requirements
- R1: While reset is applied and on the first cycle after it, `busy` is 0 and `rd_data` is 0. All registers start with the value `INIT_WORD`, which defaults to 0.
- R2: A read presents `rd_pot`/`rd_reg` before a clock edge. The addressed 6-bit word appears on `rd_data` after that edge. Reads work during the store interval as well as outside it.
- R3: A load command (`cmd_op` = 1) writes `cmd_data` into register `cmd_reg` of pot `cmd_pot`. The register keeps its old value until the edge on which a rising `cs_n` is seen, and reads the new value after that edge.
- R4: A copy command (`cmd_op` = 2) stores the wiper value of pot `cmd_pot` into that pot's register `cmd_reg`. The wiper value is taken on the edge where the command is accepted; later changes to the wiper before commit do not matter. The wiper value of pot p is `wiper_vals[6p+5:6p]`. Other pots are left unchanged.
- R5: A broadcast copy (`cmd_op` = 3) writes each pot's wiper value into register `cmd_reg` of that same pot, all on one commit edge. `cmd_pot` is ignored for this command.
- R6: A commit raises `busy` on the commit edge. `busy` then stays high for exactly `BUSY_CYCLES` clock cycles.
- R7: A command that arrives while `busy` is high is discarded. No register changes when chip select next rises.
- R8: If `wp_n` is 0 on the commit edge, no register changes and `busy` stays 0.
- R9: A chip-select rise with no command in the frame, or with only `cmd_op` = 0 in the frame, changes nothing and leaves `busy` at 0.
- R10: If a frame carries several storing commands, only the last one is committed.
- R11: A read of a register on the same edge that commits a write to it returns the old contents. The new contents are returned from the next read onward.
- R12: `cmd_valid` is ignored while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low; its rising edge commits |
| cmd_valid | input | 1 | One-cycle strobe for a complete decoded command |
| cmd_op | input | 2 | 0 none, 1 load, 2 copy, 3 broadcast copy |
| cmd_pot | input | 2 | Pot index for load and copy |
| cmd_reg | input | 2 | Register index within a pot |
| cmd_data | input | 6 | Word for a load command |
| wiper_vals | input | 24 | Current wiper settings, pot p at bits 6p+5:6p |
| wp_n | input | 1 | Write protect, active low |
| rd_pot | input | 2 | Read pot index |
| rd_reg | input | 2 | Read register index |
| rd_data | output | 6 | Read word, one cycle after the address |
| busy | output | 1 | Store interval in progress |

## Verification
Two pairs of functions can fall on the same edge. The first pair is a commit and a read of the register being written. The bench provokes this by raising chip select and presenting that read address in the same half cycle. It expects the old word on that read and the new word on the next read. The second pair is a new storing command and the store interval still running from the previous commit. The bench issues a command during the interval, checks that a read during the interval still returns data, and checks that the target register stays unchanged after the interval has ended.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
  typedef enum logic [1:0] {
    OP_NONE     = 2'd0,
    OP_LOAD     = 2'd1,
    OP_COPY     = 2'd2,
    OP_COPY_ALL = 2'd3
  } nvw_op_e;
endpackage

// File: rtl/nvw_bank.sv
module nvw_bank #(
  parameter int NREGS     = 4,
  parameter int DW        = 6,
  parameter int INIT_WORD = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(NREGS)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(NREGS)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem [NREGS];

  initial begin
    for (int i = 0; i < NREGS; i++) mem[i] = DW'(INIT_WORD);
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read-first: output register samples the old word on a colliding write
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/nvw_busy_timer.sv
module nvw_busy_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= CW'(CYCLES - 1);
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_busy_ends_at_zero_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(cnt_q) == '0);
endmodule

// File: rtl/nvw_cmd_latch.sv
module nvw_cmd_latch
  import nvw_pkg::*;
#(
  parameter int NPOTS = 4,
  parameter int NREGS = 4,
  parameter int DW    = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cs_n,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  input  logic [$clog2(NPOTS)-1:0] cmd_pot,
  input  logic [$clog2(NREGS)-1:0] cmd_reg,
  input  logic [DW-1:0]            cmd_data,
  input  logic [NPOTS*DW-1:0]      wiper_vals,
  input  logic                     wp_n,
  input  logic                     busy,
  output logic                     commit,
  output logic [NPOTS-1:0]         we,
  output logic [$clog2(NREGS)-1:0] wr_reg,
  output logic [NPOTS*DW-1:0]      wr_data
);
  localparam int PW = $clog2(NPOTS);
  localparam int RW = $clog2(NREGS);

  logic              cs_n_q;
  logic              pend_v;
  nvw_op_e           pend_op;
  logic [PW-1:0]     pend_pot;
  logic [RW-1:0]     pend_reg;
  logic [NPOTS*DW-1:0] pend_word;
  logic              cs_rise;
  logic              capture;

  assign cs_rise = cs_n && !cs_n_q;
  assign capture = cmd_valid && !cs_n && !busy && (nvw_op_e'(cmd_op) != OP_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_q    <= 1'b1;
      pend_v    <= 1'b0;
      pend_op   <= OP_NONE;
      pend_pot  <= '0;
      pend_reg  <= '0;
      pend_word <= '0;
    end else begin
      cs_n_q <= cs_n;
      if (cs_rise) begin
        pend_v <= 1'b0;
      end else if (capture) begin
        pend_v   <= 1'b1;
        pend_op  <= nvw_op_e'(cmd_op);
        pend_pot <= cmd_pot;
        pend_reg <= cmd_reg;
        for (int p = 0; p < NPOTS; p++) begin
          pend_word[p*DW +: DW] <= (nvw_op_e'(cmd_op) == OP_LOAD) ?
                                   cmd_data : wiper_vals[p*DW +: DW];
        end
      end
    end
  end

  assign commit  = cs_rise && pend_v && wp_n && !busy;
  assign wr_reg  = pend_reg;
  assign wr_data = pend_word;

  for (genvar p = 0; p < NPOTS; p++) begin : g_we
    assign we[p] = commit && (pend_op == OP_COPY_ALL || pend_pot == PW'(p));
  end

  assert_reject_while_busy_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cs_n && busy && !pend_v |=> !pend_v);
endmodule

// File: rtl/nvw_store_seq.sv
module nvw_store_seq #(
  parameter int NPOTS       = 4,
  parameter int NREGS       = 4,
  parameter int DW          = 6,
  parameter int BUSY_CYCLES = 64,
  parameter int INIT_WORD   = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cs_n,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  input  logic [$clog2(NPOTS)-1:0] cmd_pot,
  input  logic [$clog2(NREGS)-1:0] cmd_reg,
  input  logic [DW-1:0]            cmd_data,
  input  logic [NPOTS*DW-1:0]      wiper_vals,
  input  logic                     wp_n,
  input  logic [$clog2(NPOTS)-1:0] rd_pot,
  input  logic [$clog2(NREGS)-1:0] rd_reg,
  output logic [DW-1:0]            rd_data,
  output logic                     busy
);
  localparam int PW = $clog2(NPOTS);
  localparam int RW = $clog2(NREGS);

  logic                commit;
  logic [NPOTS-1:0]    we;
  logic [RW-1:0]       wr_reg;
  logic [NPOTS*DW-1:0] wr_data;
  logic [DW-1:0]       bank_q [NPOTS];
  logic [PW-1:0]       rd_pot_q;

  nvw_cmd_latch #(.NPOTS(NPOTS), .NREGS(NREGS), .DW(DW)) u_latch (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_pot(cmd_pot), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
    .wiper_vals(wiper_vals), .wp_n(wp_n), .busy(busy),
    .commit(commit), .we(we), .wr_reg(wr_reg), .wr_data(wr_data)
  );

  nvw_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(commit), .busy(busy)
  );

  for (genvar p = 0; p < NPOTS; p++) begin : g_bank
    nvw_bank #(.NREGS(NREGS), .DW(DW), .INIT_WORD(INIT_WORD)) u_bank (
      .clk(clk), .rst(rst), .we(we[p]), .waddr(wr_reg),
      .wdata(wr_data[p*DW +: DW]), .raddr(rd_reg), .rdata(bank_q[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_pot_q <= '0;
    else     rd_pot_q <= rd_pot;
  end

  assign rd_data = bank_q[rd_pot_q];

  assert_commit_unprotected_R8: assert property (@(posedge clk) disable iff (rst)
    commit |-> wp_n);
  assert_commit_only_idle_R7: assert property (@(posedge clk) disable iff (rst)
    commit |-> !busy);
  assert_busy_from_commit_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(commit));
  assert_commit_on_cs_rise_R3: assert property (@(posedge clk) disable iff (rst)
    commit |-> cs_n);
endmodule

// File: tb/tb_nvw_store_seq.sv
module tb_nvw_store_seq;
  localparam int CLK_PERIOD = 10;
  localparam int BUSYN      = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [1:0]  cmd_pot = 2'd0;
  logic [1:0]  cmd_reg = 2'd0;
  logic [5:0]  cmd_data = 6'd0;
  logic [23:0] wiper_vals = 24'd0;
  logic        wp_n = 1'b1;
  logic [1:0]  rd_pot = 2'd0;
  logic [1:0]  rd_reg = 2'd0;
  logic [5:0]  rd_data;
  logic        busy;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  logic       rd_issue = 1'b0;
  logic [5:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nvw_store_seq #(.BUSY_CYCLES(BUSYN)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_pot(cmd_pot), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
    .wiper_vals(wiper_vals), .wp_n(wp_n), .rd_pot(rd_pot), .rd_reg(rd_reg),
    .rd_data(rd_data), .busy(busy)
  );

  // monitor: pops the expected read word and compares
  initial begin : monitor
    logic [5:0] e;
    string t;
    forever begin
      @(posedge clk);
      if (rd_issue) begin
        @(negedge clk);
        if (exp_q.size() > 0) begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          n_cmp++;
          if (rd_data !== e) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h expected %h", t, rd_data, e);
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic rd(input int pot, input int rg, input logic [5:0] exp, input string tag);
    @(negedge clk);
    rd_pot = 2'(pot); rd_reg = 2'(rg); rd_issue = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_issue = 1'b0;
  endtask

  task automatic cmd(input int op, input int pot, input int rg, input int data);
    @(negedge clk);
    cmd_op = 2'(op); cmd_pot = 2'(pot); cmd_reg = 2'(rg); cmd_data = 6'(data);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic cs_lo(); @(negedge clk); cs_n = 1'b0; endtask
  task automatic cs_hi(); @(negedge clk); cs_n = 1'b1; endtask

  // raise chip select and read the target in the same cycle
  task automatic cs_hi_rd(input int pot, input int rg, input logic [5:0] exp, input string tag);
    @(negedge clk);
    cs_n = 1'b1;
    rd_pot = 2'(pot); rd_reg = 2'(rg); rd_issue = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_issue = 1'b0;
  endtask

  task automatic measure_busy(input string tag);
    int c = 0;
    @(negedge clk);
    while (busy && c < 1000) begin c++; @(negedge clk); end
    chk(c == BUSYN, tag, c, BUSYN);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(rd_data == 6'd0, "R1 rd_data after reset", rd_data, 0);

    // R2: every register starts at the init word
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 4; r++) rd(p, r, 6'd0, "R2 initial sweep");

    // R3: load is deferred until chip select rises
    cs_lo();
    cmd(1, 1, 2, 6'h2A);
    rd(1, 2, 6'd0, "R3 before commit");
    cs_hi();
    measure_busy("R6 busy length after load");
    rd(1, 2, 6'h2A, "R3 after commit");

    // R4: copy takes the wiper sampled at command time
    wiper_vals = {6'h31, 6'h22, 6'h0B, 6'h07};
    cs_lo();
    cmd(2, 3, 0, 0);
    @(negedge clk); wiper_vals[23:18] = 6'h01;
    cs_hi();
    wait_idle();
    rd(3, 0, 6'h31, "R4 copied wiper");
    rd(2, 0, 6'd0, "R4 other pot untouched");

    // R5: broadcast copy into register 1 of every pot
    wiper_vals = {6'h3E, 6'h2D, 6'h1C, 6'h0A};
    cs_lo();
    cmd(3, 2, 1, 0);
    cs_hi();
    measure_busy("R6 busy length after broadcast");
    rd(0, 1, 6'h0A, "R5 pot0");
    rd(1, 1, 6'h1C, "R5 pot1");
    rd(2, 1, 6'h2D, "R5 pot2");
    rd(3, 1, 6'h3E, "R5 pot3");

    // R7: a command during the store interval is dropped; reads still work (R2)
    cs_lo();
    cmd(1, 0, 0, 6'h15);
    cs_hi();
    cs_lo();
    cmd(1, 0, 3, 6'h3F);
    cs_hi();
    rd(0, 0, 6'h15, "R2 read during busy");
    chk(busy == 1'b1, "R2 still busy during read", busy, 1);
    wait_idle();
    rd(0, 3, 6'd0, "R7 rejected store");

    // R8: write protect cancels the commit
    wp_n = 1'b0;
    cs_lo();
    cmd(1, 2, 2, 6'h11);
    cs_hi();
    @(negedge clk);
    chk(busy == 1'b0, "R8 no busy when protected", busy, 0);
    rd(2, 2, 6'd0, "R8 register unchanged");
    wp_n = 1'b1;

    // R9: empty frame and no-op frame
    cs_lo();
    cs_hi();
    @(negedge clk);
    chk(busy == 1'b0, "R9 empty frame", busy, 0);
    cs_lo();
    cmd(0, 1, 2, 6'h3C);
    cs_hi();
    @(negedge clk);
    chk(busy == 1'b0, "R9 no-op frame", busy, 0);
    rd(1, 2, 6'h2A, "R9 register unchanged");

    // R10: last storing command in a frame wins
    cs_lo();
    cmd(1, 2, 3, 6'h05);
    cmd(1, 1, 3, 6'h33);
    cs_hi();
    wait_idle();
    rd(2, 3, 6'd0, "R10 earlier command dropped");
    rd(1, 3, 6'h33, "R10 last command stored");

    // R11: read colliding with the commit edge returns old contents
    cs_lo();
    cmd(1, 0, 1, 6'h27);
    cs_hi_rd(0, 1, 6'h0A, "R11 old word on commit edge");
    rd(0, 1, 6'h27, "R11 new word next read");
    wait_idle();

    // R12: command strobe with chip select high is ignored
    cmd(1, 3, 3, 6'h3C);
    cs_lo();
    cs_hi();
    @(negedge clk);
    chk(busy == 1'b0, "R12 no busy", busy, 0);
    rd(3, 3, 6'd0, "R12 register unchanged");

    repeat (4) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule